// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM. The host raises a request with a direction flag, a 15-bit address and, for stores, a data byte. It holds the request until the block answers with a one-cycle acknowledge. The block turns each request into a timed pattern on the memory pins: a 15-bit address, an active-low select, an active-high select, an active-low write strobe and a shared tri-state data bus.

The RAM is selected only when its low-active select is 0 and its high-active select is 1. It stores a byte on the overlap of that selection with a low write strobe, and it drives its data pins whenever it is selected with the strobe high. All phase lengths are cycle counts. Each one is the ceiling of a nanosecond parameter divided by the clock period. The defaults suit the 70 ns grade, and the parameters can be raised for the 85 ns grade.

After a read, the block also waits out the time the RAM may still drive its pins before it starts a write. This keeps the two drivers from fighting over the bus.

Top module: `sram_ctl`

## Requirements
- R1: During and after a synchronous reset, and whenever idle, the low-active select is 1, the high-active select is 0, the write strobe is 1, the data bus is not driven by the block and the acknowledge is 0.
- R2: A read holds both selects active, the strobe high and the address constant for max(ceil(tRC/T), ceil(tAA/T)) cycles (4 at defaults, T = 20 ns). The bus is sampled at the end of the last of these cycles and appears on the read-data output while the acknowledge is high.
- R3: A write first spends exactly one cycle with address and both selects active and the strobe high. It then holds the strobe low for max(ceil(tWP/T), ceil(tDW/T)+1, ceil(tWC/T)-1) cycles (3 at defaults). The RAM stores the request's byte at the request's address.
- R4: The write strobe is low only while the RAM is selected, and the address never changes between two consecutive selected cycles.
- R5: The block leaves the bus undriven in the first strobe-low cycle and drives it for every later strobe-low cycle, which is at least ceil(tDW/T) cycles. It stops driving exactly one cycle after the strobe rises and drives at no other time.
- R6: When a write request waits as a read completes, the RAM stays deselected for ceil(tHZ/T)+1 cycles (3 at defaults) before it is selected again. In the read-read, write-write and write-read cases the deselected gap is 2 cycles.
- R7: The acknowledge is high for exactly one cycle per transfer. A request held high with new fields in that cycle starts the next transfer.
- R8: Every address from 0 to 0x7FFF and every byte value is carried unchanged between the host and the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, held until acknowledged |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Byte to store |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| ram_addr | output | 15 | RAM address |
| ram_cs_n | output | 1 | Low-active RAM select |
| ram_cs | output | 1 | High-active RAM select |
| ram_we_n | output | 1 | Low-active write strobe |
| ram_dq | inout | 8 | Shared data bus |

## Verification
The hardest case to reach is a write request that is already waiting when a read finishes, because only then does the float interval set the gap before the next selection. The bench reaches it by chaining transfers. In the same negative-edge slot where the acknowledge is seen, it swaps the request fields and keeps the request high. It alternates reads and writes over 512 addresses that cover both address extremes, and it measures each deselected gap exactly. A bus model that stores on the end of the write overlap catches any byte or address that goes astray.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int CLK_NS  = 20,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 30,
  parameter int AW      = 15,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs_n,
  output logic          ram_cs,
  output logic          ram_we_n,
  inout  wire  [DW-1:0] ram_dq
);
  localparam int RC_C   = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int AA_C   = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_C   = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_C   = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DS_C   = (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int HZ_C   = (T_HZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_CYC = (RC_C > AA_C) ? RC_C : AA_C;
  localparam int W1     = (WP_C > DS_C + 1) ? WP_C : DS_C + 1;
  localparam int WR_CYC = (W1 > WC_C - 1) ? W1 : WC_C - 1;
  localparam int M1     = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CMAX   = (M1 > HZ_C) ? M1 : HZ_C;
  localparam int CW     = $clog2(CMAX + 1);

  typedef enum logic [2:0] {IDLE, RD, RD_END, WR_SET, WR_PULSE, WR_END} st_t;
  st_t st;
  logic [CW-1:0] cnt, fz;
  logic [DW-1:0] wd_q;
  logic          oe;

  assign ram_dq = oe ? wd_q : 'z;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; cnt <= '0; fz <= '0; oe <= 1'b0; ack <= 1'b0;
      ram_cs_n <= 1'b1; ram_cs <= 1'b0; ram_we_n <= 1'b1;
      ram_addr <= '0; wd_q <= '0; rsp_rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (fz != '0) fz <= fz - 1'b1;
      case (st)
        IDLE: begin
          oe <= 1'b0;
          if (req && (!req_wr || fz == '0)) begin
            ram_addr <= req_addr;
            ram_cs_n <= 1'b0;
            ram_cs   <= 1'b1;
            if (req_wr) begin
              wd_q <= req_wdata;
              st   <= WR_SET;
            end else begin
              cnt <= CW'(RD_CYC - 1);
              st  <= RD;
            end
          end
        end
        RD: begin
          if (cnt == '0) begin
            rsp_rdata <= ram_dq;
            ram_cs_n  <= 1'b1;
            ram_cs    <= 1'b0;
            ack       <= 1'b1;
            fz        <= CW'(HZ_C);
            st        <= RD_END;
          end else cnt <= cnt - 1'b1;
        end
        RD_END: st <= IDLE;
        WR_SET: begin
          ram_we_n <= 1'b0;
          cnt      <= CW'(WR_CYC - 1);
          st       <= WR_PULSE;
        end
        WR_PULSE: begin
          oe <= 1'b1;
          if (cnt == '0) begin
            ram_we_n <= 1'b1;
            ram_cs_n <= 1'b1;
            ram_cs   <= 1'b0;
            ack      <= 1'b1;
            st       <= WR_END;
          end else cnt <= cnt - 1'b1;
        end
        WR_END: begin
          oe <= 1'b0;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R4
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!ram_cs_n && ram_cs));
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));
  // R5
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    oe |-> (!ram_we_n || $past(!ram_we_n)));
  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (st == IDLE) |-> (ram_cs_n && !ram_cs && ram_we_n && !oe));
  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (fz == '0));
endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
  localparam int T = 20;
  function automatic int cdiv(input int ns);
    return (ns + T - 1) / T;
  endfunction
  localparam int RDX = (cdiv(70) > cdiv(70)) ? cdiv(70) : cdiv(70);
  localparam int WA  = (cdiv(55) > cdiv(30) + 1) ? cdiv(55) : cdiv(30) + 1;
  localparam int WRX = (WA > cdiv(70) - 1) ? WA : cdiv(70) - 1;
  localparam int DSX = cdiv(30);
  localparam int HZX = cdiv(30);

  logic clk = 0, rst = 1, req = 0, req_wr = 0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ack;
  logic [7:0] rsp_rdata;
  logic [14:0] ram_addr;
  logic ram_cs_n, ram_cs, ram_we_n;
  wire  [7:0] ram_dq;

  always #(T/2) clk = ~clk;

  sram_ctl u_sram_ctl (.clk(clk), .rst(rst), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_cs(ram_cs), .ram_we_n(ram_we_n),
    .ram_dq(ram_dq));

  logic [7:0] mm [512];
  logic [5:0] tg [512];
  logic       vl [512];
  wire rd_act = !ram_cs_n && ram_cs && ram_we_n;
  wire wr_act = !ram_cs_n && ram_cs && !ram_we_n;
  wire [8:0] midx = ram_addr[8:0];
  wire [7:0] mout = (vl[midx] && tg[midx] == ram_addr[14:9]) ? mm[midx] : 8'hEE;
  assign ram_dq = rd_act ? mout : 8'bzzzzzzzz;

  initial for (int k = 0; k < 512; k++) vl[k] = 1'b0;
  always @(negedge wr_act) if (!rst) begin
    mm[midx] = ram_dq;
    tg[midx] = ram_addr[14:9];
    vl[midx] = 1'b1;
  end

  int checks = 0, fails = 0;
  logic [7:0] shadow [512];
  logic cur_wr = 0, chained = 0, last_rd = 0, have_last = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // monitor of pin timing
  int sel_n_c = 0, low_c = 0, drv_low = 0, setup_c = 0, desel_c = 0;
  logic prev_sel = 0, prev_we_n = 1, prev_ack = 0;
  always @(negedge clk) if (!rst) begin
    logic selnow, drv;
    int expg;
    selnow = !ram_cs_n && ram_cs;
    drv = (ram_dq !== 8'bzzzzzzzz) && !rd_act;
    if (selnow) begin
      if (!prev_sel) begin
        if (have_last) begin
          expg = (last_rd && cur_wr) ? HZX + 1 : 2;
          if (chained) chk(desel_c == expg, "R6 gap", desel_c, expg);
          else chk(desel_c >= expg, "R6 min gap", desel_c, expg);
        end
        sel_n_c = 0; low_c = 0; drv_low = 0; setup_c = 0;
      end
      sel_n_c++;
      if (!ram_we_n) begin
        low_c++;
        if (drv) drv_low++;
        if (low_c == 1 && drv) chk(0, "R5 early drive", 1, 0);
      end else if (low_c == 0) setup_c++;
    end
    if (!selnow && prev_sel) begin
      if (low_c == 0) begin
        chk(sel_n_c == RDX, "R2 read length", sel_n_c, RDX);
        last_rd = 1;
      end else begin
        chk(setup_c == 1, "R3 setup cycle", setup_c, 1);
        chk(low_c == WRX, "R3 strobe length", low_c, WRX);
        chk(drv_low == WRX - 1 && drv_low >= DSX, "R5 data before end", drv_low, WRX - 1);
        last_rd = 0;
      end
      have_last = 1;
      desel_c = 0;
    end
    if (!selnow) desel_c++;
    if (drv && ram_we_n && prev_we_n) chk(0, "R5 stray drive", 1, 0);
    if (ack && prev_ack) chk(0, "R7 ack width", 2, 1);
    prev_sel = selnow; prev_we_n = ram_we_n; prev_ack = ack;
  end

  task automatic xfer(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit ch);
    int n = 0;
    chained = ch; cur_wr = wr;
    req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      n++;
      if (ack) break;
      if (n > 100) begin
        chk(0, "R7 watchdog", n, RDX + 2);
        summary();
      end
    end
    if (wr) shadow[a[8:0]] = d;
    else chk(rsp_rdata == shadow[a[8:0]], "R2 R8 read data", rsp_rdata, shadow[a[8:0]]);
  endtask

  function automatic logic [14:0] adr(input int i);
    logic [5:0] hi;
    hi = (i == 511) ? 6'h3F : (i == 0) ? 6'h00 : 6'((i * 37) & 63);
    return {hi, 9'(i)};
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        chk(0, "watchdog", cyc, 190000);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ram_cs_n && !ram_cs && ram_we_n && !ack && ram_dq === 8'bzzzzzzzz,
        "R1 reset pins", {ram_cs_n, ram_cs, ram_we_n, ack}, 4'b1010);
    rst = 0;
    @(negedge clk);
    chk(ram_cs_n && !ram_cs && ram_we_n && !ack && ram_dq === 8'bzzzzzzzz,
        "R1 idle pins", {ram_cs_n, ram_cs, ram_we_n, ack}, 4'b1010);
    for (int i = 0; i < 512; i++) begin
      xfer(1, adr(i), 8'((i * 29 + 7) & 255), 0);
      req = 0;
      @(negedge clk);
    end
    for (int i = 0; i < 512; i++) xfer(0, adr(i), 8'h00, i != 0);
    for (int i = 0; i < 512; i++) begin
      xfer(0, adr(i), 8'h00, 1);
      xfer(1, adr(i), 8'(~((i * 29 + 7) ^ i)), 1);
    end
    req = 0;
    @(negedge clk);
    for (int i = 0; i < 512; i++) begin
      xfer(0, adr(i), 8'h00, 0);
      req = 0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(ram_cs_n && !ram_cs && ram_we_n && !ack && ram_dq === 8'bzzzzzzzz,
        "R1 idle after traffic", {ram_cs_n, ram_cs, ram_we_n, ack}, 4'b1010);
    summary();
  end
endmodule